// File: doc/BRIEF.md
# Three-Digit Decimal Arithmetic Unit

This block adds or subtracts two unsigned decimal numbers in the range 000 to 999. Each number arrives as three packed BCD digits. The result is a three-digit BCD value that wraps modulo 1000. Alongside it the block gives a zero indication and a non-negative indication, so that an accumulator-style controller can make conditional branch decisions. A carry or borrow past the hundreds digit is dropped and is never reported.

The unit samples its operands and its operation select on every rising clock edge. It registers the result and the flags on that same edge. Subtraction adds the nine's complement of the second operand, with a carry-in of one. The carry out of the top digit then tells whether the true difference was negative. If any input digit is not a legal BCD code, the block raises an error flag and forces a defined result.

Top module: `bcd3_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs take these values: `result` = 000, `zero` = 1, `positive` = 1, `bcd_err` = 0.
- R2: The unit samples its inputs at a rising edge. The outputs show that operation's outcome from the same edge until the next one. A new operation is accepted on every cycle.
- R3: Digit encoding is as follows. Units are in bits 3:0, tens in bits 7:4 and hundreds in bits 11:8, each a 4-bit BCD code from 0 to 9. `op_sub` = 0 selects addition and `op_sub` = 1 selects subtraction.
- R4: Addition gives (A + B) mod 1000, and any carry out of the hundreds digit is dropped. For example, 999 + 001 gives 000.
- R5: Subtraction gives (A − B) mod 1000 in ten's complement. For example, 000 − 001 gives 999.
- R6: After an addition with valid inputs, `positive` is 1. After a subtraction with valid inputs, `positive` is 1 exactly when A ≥ B, so it stays 1 for a zero difference.
- R7: `zero` is 1 exactly when all three result digits are 0. This includes a result of 000 that comes from wraparound.
- R8: If any nibble of either operand exceeds 9, the outputs are forced as follows: `bcd_err` = 1, `result` = 000, `zero` = 0, `positive` = 0.
- R9: Every digit of `result` is always a legal BCD code from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_a | input | 12 | First operand, three BCD digits |
| opnd_b | input | 12 | Second operand, three BCD digits |
| op_sub | input | 1 | 0 = add, 1 = subtract A minus B |
| result | output | 12 | Registered BCD result modulo 1000 |
| zero | output | 1 | Result digits are all zero |
| positive | output | 1 | True result was zero or greater |
| bcd_err | output | 1 | An operand held a nibble above 9 |

## Verification
The embedded properties assume that every input is at a defined 0/1 level on each rising edge once reset is released. The equal-operand and add-sign properties also assume that their antecedents are met only by legal BCD codes. The stimulus drives all inputs on the falling edge, so they are always stable at the sampling edge. Most random operands are built digit by digit from the range 0 to 9. A minority of cycles replaces one chosen nibble with a code from 10 to 15, which keeps the error path separate from the arithmetic checks.

// File: rtl/bcd3_pkg.sv
// Shared constants and helpers for the decimal arithmetic unit.
// Assumes the packed digit layout: units in the lowest nibble.
package bcd3_pkg;
    localparam int DIGW   = 4;
    localparam int DIGMAX = 9;

    typedef enum logic {
        OPSEL_ADD = 1'b0,
        OPSEL_SUB = 1'b1
    } opsel_e;

    // Nine's complement of one legal digit.
    function automatic logic [DIGW-1:0] nines(input logic [DIGW-1:0] d);
        return 4'(DIGMAX) - d;
    endfunction
endpackage

// File: rtl/bcd_digit_check.sv
// Flags whether one 4-bit nibble is a legal decimal digit (0..9).
// Purely combinational; no assumption on the input value.
module bcd_digit_check
    import bcd3_pkg::*;
(
    input  logic [DIGW-1:0] nib,
    output logic            legal
);
    // Compare against the largest legal code.
    always_comb legal = (nib <= 4'(DIGMAX));
endmodule

// File: rtl/bcd_digit_add.sv
// One decimal digit of a ripple adder: da + db + cin, decimal-corrected.
// Assumes both digit inputs are legal BCD (0..9); the sum is then 0..19.
module bcd_digit_add
    import bcd3_pkg::*;
(
    input  logic [DIGW-1:0] da,
    input  logic [DIGW-1:0] db,
    input  logic            cin,
    output logic [DIGW-1:0] dsum,
    output logic            cout
);
    logic [DIGW:0] raw;
    logic [DIGW:0] adj;

    // Binary sum, then subtract ten when it passes nine.
    always_comb begin
        raw  = {1'b0, da} + {1'b0, db} + {{DIGW{1'b0}}, cin};
        cout = (raw > 5'(DIGMAX));
        adj  = cout ? (raw - 5'd10) : raw;
        dsum = adj[DIGW-1:0];
    end
endmodule

// File: rtl/bcd3_alu.sv
// Registered N-digit BCD add/subtract unit with zero and non-negative flags.
// Subtraction adds the nine's complement of B with carry-in 1; the final
// carry is 1 exactly when A >= B. A carry past the top digit is dropped.
// Illegal BCD nibbles force result 0, zero 0, positive 0 and raise bcd_err.
// Assumes inputs are settled before each rising edge.
module bcd3_alu
    import bcd3_pkg::*;
#(
    parameter int NDIG = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NDIG*DIGW-1:0] opnd_a,
    input  logic [NDIG*DIGW-1:0] opnd_b,
    input  logic                 op_sub,
    output logic [NDIG*DIGW-1:0] result,
    output logic                 zero,
    output logic                 positive,
    output logic                 bcd_err
);
    localparam int W = NDIG * DIGW;

    opsel_e          opsel;
    logic [NDIG:0]   carry;
    logic [W-1:0]    b_eff;
    logic [W-1:0]    sum_w;
    logic [NDIG-1:0] a_ok;
    logic [NDIG-1:0] b_ok;
    logic            all_ok;
    logic            nonneg;

    // Decode the operation select.
    always_comb opsel = opsel_e'(op_sub);

    assign carry[0] = (opsel == OPSEL_SUB);

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        // Choose B or its nine's complement for this digit.
        always_comb b_eff[i*DIGW +: DIGW] = (opsel == OPSEL_SUB)
            ? nines(opnd_b[i*DIGW +: DIGW]) : opnd_b[i*DIGW +: DIGW];

        bcd_digit_check u_chk_a (.nib(opnd_a[i*DIGW +: DIGW]), .legal(a_ok[i]));
        bcd_digit_check u_chk_b (.nib(opnd_b[i*DIGW +: DIGW]), .legal(b_ok[i]));

        bcd_digit_add u_add (
            .da  (opnd_a[i*DIGW +: DIGW]),
            .db  (b_eff[i*DIGW +: DIGW]),
            .cin (carry[i]),
            .dsum(sum_w[i*DIGW +: DIGW]),
            .cout(carry[i+1])
        );

        // Each stored digit is a legal BCD code (R9).
        assert_digit_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
            result[i*DIGW +: DIGW] <= 4'(DIGMAX));
    end

    // Combine legality and derive the sign of the true result.
    always_comb begin
        all_ok = (&a_ok) & (&b_ok);
        nonneg = (opsel == OPSEL_ADD) ? 1'b1 : carry[NDIG];
    end

    // Register result and flags; reset and illegal inputs give fixed values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            zero     <= 1'b1;
            positive <= 1'b1;
            bcd_err  <= 1'b0;
        end else if (!all_ok) begin
            result   <= '0;
            zero     <= 1'b0;
            positive <= 1'b0;
            bcd_err  <= 1'b1;
        end else begin
            result   <= sum_w;
            zero     <= (sum_w == '0);
            positive <= nonneg;
            bcd_err  <= 1'b0;
        end
    end

    // Zero flag agrees with the stored digits unless in error (R7).
    assert_zero_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bcd_err |-> (zero == (result == '0)));

    // Error state carries the forced output values (R8).
    assert_err_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_err |-> (result == '0 && !zero && !positive));

    // A legal addition always reports a non-negative result (R6).
    assert_add_nonneg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_sub && all_ok) |=> (positive && !bcd_err));

    // Subtracting equal legal operands gives zero and non-negative (R5).
    assert_sub_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sub && all_ok && opnd_a == opnd_b) |=> (zero && positive && result == '0));
endmodule

// File: tb/sim_bcd3_alu.sv
// Self-checking bench: directed corners plus seeded random operands.
module sim_bcd3_alu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] opnd_a, opnd_b;
    logic        op_sub;
    logic [11:0] result;
    logic        zero, positive, bcd_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bcd3_alu u0 (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sub(op_sub), .result(result), .zero(zero),
        .positive(positive), .bcd_err(bcd_err)
    );

    function automatic int from_bcd(input logic [11:0] v);
        return int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [11:0] to_bcd(input int n);
        return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
    endfunction

    function automatic bit legal(input logic [11:0] v);
        return v[11:8] <= 9 && v[7:4] <= 9 && v[3:0] <= 9;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Apply one operation and compare every output against the model.
    task automatic run_op(input logic [11:0] a, input logic [11:0] b, input logic s, input string req);
        int ia, ib, r;
        bit ok, pos;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sub = s;
        @(posedge clk);
        #1;
        ok = legal(a) && legal(b);
        ia = from_bcd(a); ib = from_bcd(b);
        if (!ok) begin
            check(req, "err flag", int'(bcd_err), 1);
            check(req, "err result", int'(result), 0);
            check(req, "err zero", int'(zero), 0);
            check(req, "err positive", int'(positive), 0);
        end else begin
            r   = s ? ((ia - ib + 1000) % 1000) : ((ia + ib) % 1000);
            pos = s ? (ia >= ib) : 1'b1;
            check(req, "result", int'(result), int'(to_bcd(r)));
            check("R7", "zero", int'(zero), int'(r == 0));
            check("R6", "positive", int'(positive), int'(pos));
            check("R8", "no err", int'(bcd_err), 0);
        end
        check("R9", "digits legal", int'(legal(result)), 1);
    endtask

    initial begin
        int n;
        for (n = 0; n < 100000 && !done; n++) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] a, b;
        void'($urandom(32'd4242));
        rst_n = 1'b0; opnd_a = 12'h123; opnd_b = 12'h456; op_sub = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset values
        check("R1", "reset result", int'(result), 0);
        check("R1", "reset zero", int'(zero), 1);
        check("R1", "reset positive", int'(positive), 1);
        check("R1", "reset err", int'(bcd_err), 0);
        @(negedge clk); rst_n = 1'b1;

        // R4 addition corners, including wrap to zero
        run_op(12'h999, 12'h001, 1'b0, "R4");
        run_op(12'h456, 12'h321, 1'b0, "R4");
        run_op(12'h999, 12'h999, 1'b0, "R4");
        run_op(12'h000, 12'h000, 1'b0, "R4");
        run_op(12'h095, 12'h005, 1'b0, "R4");
        // R5 subtraction corners, borrow wrap and equal operands
        run_op(12'h000, 12'h001, 1'b1, "R5");
        run_op(12'h500, 12'h500, 1'b1, "R5");
        run_op(12'h100, 12'h001, 1'b1, "R5");
        run_op(12'h001, 12'h999, 1'b1, "R5");
        // R3 digit positions: units only, tens only, hundreds only
        run_op(12'h001, 12'h010, 1'b0, "R3");
        run_op(12'h100, 12'h010, 1'b1, "R3");
        // R8 illegal nibbles in each operand
        run_op(12'h00A, 12'h000, 1'b0, "R8");
        run_op(12'h123, 12'hF00, 1'b1, "R8");
        run_op(12'h123, 12'h111, 1'b0, "R2");

        // R2 back-to-back random operations, one per cycle
        for (int k = 0; k < 400; k++) begin
            a = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
            b = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
            if ($urandom_range(0, 7) == 0) begin
                if ($urandom_range(0, 1) == 0)
                    a[4*$urandom_range(0, 2) +: 4] = 4'($urandom_range(10, 15));
                else
                    b[4*$urandom_range(0, 2) +: 4] = 4'($urandom_range(10, 15));
            end
            run_op(a, b, 1'($urandom_range(0, 1)), "R2");
        end

        // R1 reset clears a non-zero state
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1", "re-reset result", int'(result), 0);
        check("R1", "re-reset err", int'(bcd_err), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule